// File: doc/BRIEF.md
# Auxiliary Link Packet Framer and Checker

This block connects a byte-wide packet source and sink to a word-wide frame buffer shared with an auxiliary serial link. On the send side it accepts a packet body one byte per clock, fills it with zero bytes up to the next 32-bit boundary, and adds a CRC-32 word at the end. It writes the frame into the lower half of the buffer, presents the total frame length, and then pulses a start request to the link.

On the receive side the link reports that a frame is waiting in the upper half of the buffer, along with its length and a sticky overflow flag. The block first rejects frames that are too small. Otherwise it reads the frame once to recompute the CRC-32 and compare it with the trailing word. It reads the frame a second time, restoring byte order, only when the checksum matches. Every frame ends with one status pulse (ok, corrupt, short or overflow) and a clear pulse back to the link.

Top module: `aux_link_framer`

## Requirements
- R1: A sent body of N bytes is followed by zero bytes up to P = 4*ceil(N/4) bytes, with no padding when N is already a multiple of 4. `tx_len` equals P + 4.
- R2: The last frame word carries the CRC-32 of the P padded bytes. The CRC uses the reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion. With C the CRC value, the word is {C[7:0], C[15:8], C[23:16], C[31:24]}.
- R3: Frame word i (not the CRC word) holds byte 4i in bits 31:24, byte 4i+1 in bits 23:16, byte 4i+2 in bits 15:8 and byte 4i+3 in bits 7:0. Send words are written at buffer address i (lower half). Receive words are read at address MAX_FRAME/4 + i (upper half).
- R4: `tx_start` is a one-cycle pulse that comes after the last buffer write. `tx_len` already holds its final value in the cycle before the pulse and does not change in the pulse cycle.
- R5: While `tx_busy` is high, and in the cycle of a start pulse, `tx_in_ready` is low, so no byte of a new packet is accepted.
- R6: A received frame whose length (rounded down to a multiple of 4) is below 8 bytes gives a `st_short` pulse and no output bytes.
- R7: A received frame whose trailing word differs from the recomputed checksum (same encoding as R2) gives a `st_corrupt` pulse and no output bytes.
- R8: A received frame whose checksum matches delivers its len-4 leading bytes in order on `rx_out_*`. The final byte is marked by `rx_out_last`, and `st_ok` pulses in that same cycle.
- R9: A raised `rx_overflow` takes precedence over a pending frame: no bytes are delivered and `st_overflow` pulses. `rx_present_clr` pulses exactly one cycle before `rx_error_clr`.
- R10: Each handled frame produces exactly one one-cycle `rx_present_clr` pulse. At most one status pulse is high in any cycle.
- R11: After reset all strobes, status pulses and `rx_out_valid` are low, and `tx_in_ready` is high while `tx_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_valid | input | 1 | Send body byte valid |
| tx_in_data | input | 8 | Send body byte |
| tx_in_last | input | 1 | Marks final body byte |
| tx_in_ready | output | 1 | Block accepts a body byte this cycle |
| tx_busy | input | 1 | Link still sending previous frame |
| buf_wr_en | output | 1 | Buffer word write strobe |
| buf_wr_addr | output | AW (9) | Buffer word write address |
| buf_wr_data | output | 32 | Buffer word write data |
| tx_len | output | LENW (11) | Send frame length in bytes |
| tx_start | output | 1 | Start request pulse to the link |
| buf_rd_addr | output | AW (9) | Buffer word read address |
| buf_rd_data | input | 32 | Read data, one cycle after address |
| rx_present | input | 1 | Received frame waiting |
| rx_len | input | LENW (11) | Received frame length in bytes (multiple of 4) |
| rx_overflow | input | 1 | Link receive overflow flag |
| rx_present_clr | output | 1 | Write-one clear of the present flag |
| rx_error_clr | output | 1 | Write-one clear of the overflow flag |
| rx_out_valid | output | 1 | Received body byte valid |
| rx_out_data | output | 8 | Received body byte |
| rx_out_last | output | 1 | Final received body byte |
| st_ok | output | 1 | Frame good pulse |
| st_corrupt | output | 1 | Checksum mismatch pulse |
| st_short | output | 1 | Frame too short pulse |
| st_overflow | output | 1 | Overflow handled pulse |

## Verification
The bound checker verifies the timing rules on every cycle. These cover the start pulse width and the settled length before it, the ready gating under busy, send writes staying in the lower half, the present-then-error clear order, single status pulses, and the ok pulse coinciding with the last byte. Only the bench scenarios can show the data contents. These are the padded word images, the checksum word, byte-order restoration, suppression of output on bad frames, and a send-to-receive loopback through the bench's buffer model.

// File: rtl/aux_link_pkg.sv
package aux_link_pkg;

  typedef enum logic [2:0] {T_IDLE, T_BODY, T_PAD, T_CRC, T_GO} tx_state_e;
  typedef enum logic [2:0] {R_IDLE, R_CHK, R_OUT, R_OVF, R_WAIT} rx_state_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // advance a reflected CRC-32 register by one byte
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  // finished checksum as it sits in the unswapped trailing word
  function automatic logic [31:0] crc_word(input logic [31:0] f);
    return {f[7:0], f[15:8], f[23:16], f[31:24]};
  endfunction

endpackage

// File: rtl/aux_tx_framer.sv
module aux_tx_framer
  import aux_link_pkg::*;
#(
  parameter int AW   = 9,
  parameter int LENW = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            in_ready,
  input  logic            tx_busy,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [31:0]     wr_data,
  output logic [LENW-1:0] tx_len,
  output logic            tx_start
);

  tx_state_e       st;
  logic [LENW-1:0] cnt;
  logic [23:0]     sh;
  logic [31:0]     crc;
  logic            take, feed;
  logic [7:0]      fb;

  assign in_ready = ((st == T_IDLE) && !tx_busy && !tx_start) || (st == T_BODY);
  assign take     = in_valid && in_ready;
  assign feed     = take || (st == T_PAD);
  assign fb       = (st == T_PAD) ? 8'd0 : in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      cnt      <= '0;
      sh       <= '0;
      crc      <= '1;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      tx_len   <= '0;
      tx_start <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      tx_start <= 1'b0;
      if (feed) begin
        crc <= crc_step(crc, fb);
        sh  <= {sh[15:0], fb};
        cnt <= cnt + 1'b1;
        if (cnt[1:0] == 2'd3) begin
          // first byte of the word lands in the top lane
          wr_en   <= 1'b1;
          wr_addr <= AW'(cnt >> 2);
          wr_data <= {sh, fb};
        end
      end
      case (st)
        T_IDLE, T_BODY:
          if (take)
            st <= in_last ? ((cnt[1:0] == 2'd3) ? T_CRC : T_PAD) : T_BODY;
        T_PAD:
          if (cnt[1:0] == 2'd3) st <= T_CRC;
        T_CRC: begin
          wr_en   <= 1'b1;
          wr_addr <= AW'(cnt >> 2);
          wr_data <= crc_word(~crc);
          tx_len  <= cnt + LENW'(4);
          st      <= T_GO;
        end
        T_GO: begin
          tx_start <= 1'b1;
          cnt      <= '0;
          crc      <= '1;
          st       <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aux_rx_checker.sv
module aux_rx_checker
  import aux_link_pkg::*;
#(
  parameter int AW      = 9,
  parameter int LENW    = 11,
  parameter int RX_BASE = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_present,
  input  logic [LENW-1:0] rx_len,
  input  logic            rx_overflow,
  output logic [AW-1:0]   rd_addr,
  input  logic [31:0]     rd_data,
  output logic            present_clr,
  output logic            error_clr,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_last,
  output logic            st_ok,
  output logic            st_corrupt,
  output logic            st_short,
  output logic            st_overflow
);

  localparam logic [LENW-1:0] MIN_LEN = LENW'(8);

  rx_state_e       st;
  logic [LENW-1:0] nbody, rc, p_idx, limit, len_r;
  logic            p_vld, issue;
  logic [31:0]     crc;
  logic [7:0]      pb;

  assign len_r   = {rx_len[LENW-1:2], 2'b00};
  assign limit   = (st == R_CHK) ? nbody : nbody - 1'b1;
  assign issue   = ((st == R_CHK) || (st == R_OUT)) && (rc <= limit);
  assign rd_addr = AW'(RX_BASE) + AW'(rc >> 2);

  // undo the in-word byte reversal
  always_comb begin
    case (p_idx[1:0])
      2'd0:    pb = rd_data[31:24];
      2'd1:    pb = rd_data[23:16];
      2'd2:    pb = rd_data[15:8];
      default: pb = rd_data[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= R_IDLE;
      nbody       <= '0;
      rc          <= '0;
      p_idx       <= '0;
      p_vld       <= 1'b0;
      crc         <= '1;
      present_clr <= 1'b0;
      error_clr   <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_last    <= 1'b0;
      st_ok       <= 1'b0;
      st_corrupt  <= 1'b0;
      st_short    <= 1'b0;
      st_overflow <= 1'b0;
    end else begin
      present_clr <= 1'b0;
      error_clr   <= 1'b0;
      out_valid   <= 1'b0;
      out_last    <= 1'b0;
      st_ok       <= 1'b0;
      st_corrupt  <= 1'b0;
      st_short    <= 1'b0;
      st_overflow <= 1'b0;
      p_vld       <= issue;
      p_idx       <= rc;
      if (issue) rc <= rc + 1'b1;
      case (st)
        R_IDLE:
          if (rx_overflow) begin
            present_clr <= 1'b1;
            st          <= R_OVF;
          end else if (rx_present) begin
            if (len_r < MIN_LEN) begin
              st_short    <= 1'b1;
              present_clr <= 1'b1;
              st          <= R_WAIT;
            end else begin
              nbody <= len_r - LENW'(4);
              rc    <= '0;
              crc   <= '1;
              st    <= R_CHK;
            end
          end
        R_CHK:
          if (p_vld) begin
            if (p_idx == nbody) begin
              if (rd_data == crc_word(~crc)) begin
                rc    <= '0;
                p_vld <= 1'b0;
                st    <= R_OUT;
              end else begin
                st_corrupt  <= 1'b1;
                present_clr <= 1'b1;
                st          <= R_WAIT;
              end
            end else begin
              crc <= crc_step(crc, pb);
            end
          end
        R_OUT:
          if (p_vld) begin
            out_valid <= 1'b1;
            out_data  <= pb;
            if (p_idx == nbody - 1'b1) begin
              out_last    <= 1'b1;
              st_ok       <= 1'b1;
              present_clr <= 1'b1;
              st          <= R_WAIT;
            end
          end
        R_OVF: begin
          error_clr   <= 1'b1;
          st_overflow <= 1'b1;
          st          <= R_WAIT;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aux_link_framer.sv
module aux_link_framer #(
  parameter int MAX_FRAME = 1024,
  localparam int AW       = $clog2(MAX_FRAME / 2),
  localparam int LENW     = $clog2(MAX_FRAME + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_in_valid,
  input  logic [7:0]      tx_in_data,
  input  logic            tx_in_last,
  output logic            tx_in_ready,
  input  logic            tx_busy,
  output logic            buf_wr_en,
  output logic [AW-1:0]   buf_wr_addr,
  output logic [31:0]     buf_wr_data,
  output logic [LENW-1:0] tx_len,
  output logic            tx_start,
  output logic [AW-1:0]   buf_rd_addr,
  input  logic [31:0]     buf_rd_data,
  input  logic            rx_present,
  input  logic [LENW-1:0] rx_len,
  input  logic            rx_overflow,
  output logic            rx_present_clr,
  output logic            rx_error_clr,
  output logic            rx_out_valid,
  output logic [7:0]      rx_out_data,
  output logic            rx_out_last,
  output logic            st_ok,
  output logic            st_corrupt,
  output logic            st_short,
  output logic            st_overflow
);

  localparam int RX_BASE = MAX_FRAME / 4;

  aux_tx_framer #(.AW(AW), .LENW(LENW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .in_valid (tx_in_valid),
    .in_data  (tx_in_data),
    .in_last  (tx_in_last),
    .in_ready (tx_in_ready),
    .tx_busy  (tx_busy),
    .wr_en    (buf_wr_en),
    .wr_addr  (buf_wr_addr),
    .wr_data  (buf_wr_data),
    .tx_len   (tx_len),
    .tx_start (tx_start)
  );

  aux_rx_checker #(.AW(AW), .LENW(LENW), .RX_BASE(RX_BASE)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .rx_present  (rx_present),
    .rx_len      (rx_len),
    .rx_overflow (rx_overflow),
    .rd_addr     (buf_rd_addr),
    .rd_data     (buf_rd_data),
    .present_clr (rx_present_clr),
    .error_clr   (rx_error_clr),
    .out_valid   (rx_out_valid),
    .out_data    (rx_out_data),
    .out_last    (rx_out_last),
    .st_ok       (st_ok),
    .st_corrupt  (st_corrupt),
    .st_short    (st_short),
    .st_overflow (st_overflow)
  );

endmodule

// File: rtl/aux_link_framer_chk.sv
module aux_link_framer_chk #(
  parameter int AW      = 9,
  parameter int LENW    = 11,
  parameter int RX_BASE = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            tx_in_ready,
  input logic            tx_busy,
  input logic            buf_wr_en,
  input logic [AW-1:0]   buf_wr_addr,
  input logic [LENW-1:0] tx_len,
  input logic            tx_start,
  input logic            rx_present_clr,
  input logic            rx_error_clr,
  input logic            rx_out_valid,
  input logic            rx_out_last,
  input logic            st_ok,
  input logic            st_corrupt,
  input logic            st_short,
  input logic            st_overflow
);

  a_r5_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> !tx_in_ready);

  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  a_r4_len_settled: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $stable(tx_len));

  a_r3_tx_lower_half: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> (buf_wr_addr < AW'(RX_BASE)));

  a_r9_clear_order: assert property (@(posedge clk) disable iff (rst)
    rx_error_clr |-> $past(rx_present_clr));

  a_r10_status_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_ok, st_corrupt, st_short, st_overflow}));

  a_r10_clr_single: assert property (@(posedge clk) disable iff (rst)
    rx_present_clr |=> !rx_present_clr);

  a_r8_ok_with_last: assert property (@(posedge clk) disable iff (rst)
    st_ok |-> (rx_out_valid && rx_out_last));

endmodule

bind aux_link_framer aux_link_framer_chk #(.AW(AW), .LENW(LENW), .RX_BASE(RX_BASE)) u_chk (.*);

// File: tb/aux_link_framer_tb.sv
`timescale 1ns/1ps
module aux_link_framer_tb;

  localparam int MAX_FRAME = 1024;
  localparam int AW        = $clog2(MAX_FRAME / 2);
  localparam int LENW      = $clog2(MAX_FRAME + 1);
  localparam int RXB       = MAX_FRAME / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic            tx_in_valid = 0, tx_in_last = 0, tx_busy = 0;
  logic [7:0]      tx_in_data = 0;
  logic            tx_in_ready, buf_wr_en, tx_start;
  logic [AW-1:0]   buf_wr_addr, buf_rd_addr;
  logic [31:0]     buf_wr_data, buf_rd_data;
  logic [LENW-1:0] tx_len;
  logic            rx_present = 0, rx_overflow = 0;
  logic [LENW-1:0] rx_len = 0;
  logic            rx_present_clr, rx_error_clr, rx_out_valid, rx_out_last;
  logic [7:0]      rx_out_data;
  logic            st_ok, st_corrupt, st_short, st_overflow;

  aux_link_framer #(.MAX_FRAME(MAX_FRAME)) u_dut (.*);

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [31:0] mem [0:MAX_FRAME/2-1];
  logic [7:0]  pkt [0:63];

  // link-side model
  int busy_hold = 4, busy_cnt = 0;
  logic [LENW-1:0] lat_len = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (buf_wr_en) mem[buf_wr_addr] <= buf_wr_data;
    buf_rd_data <= mem[buf_rd_addr];
    if (rst) begin
      tx_busy <= 0; busy_cnt <= 0;
    end else if (tx_start) begin
      tx_busy <= 1; busy_cnt <= busy_hold; lat_len <= tx_len;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) tx_busy <= 0;
    end
    if (rx_present_clr) rx_present <= 0;
    if (rx_error_clr) rx_overflow <= 0;
  end

  // output monitor
  logic [7:0] out_q [$];
  int n_ok = 0, n_cor = 0, n_sh = 0, n_ovf = 0, n_pclr = 0, n_last = 0;
  int n_start = 0, start_cyc = 0, pclr_cyc = 0, eclr_cyc = 0, len_bad = 0;
  logic [LENW-1:0] prev_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_out_valid) out_q.push_back(rx_out_data);
      if (rx_out_valid && rx_out_last) n_last++;
      if (st_ok) n_ok++;
      if (st_corrupt) n_cor++;
      if (st_short) n_sh++;
      if (st_overflow) n_ovf++;
      if (rx_present_clr) begin n_pclr++; pclr_cyc = cyc; end
      if (rx_error_clr) eclr_cyc = cyc;
      if (tx_start) begin
        n_start++; start_cyc = cyc;
        if (tx_len != prev_len) len_bad++;
      end
    end
    prev_len = tx_len;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'd0, pkt[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] sw_word(input int w);
    return {pkt[4*w], pkt[4*w+1], pkt[4*w+2], pkt[4*w+3]};
  endfunction

  function automatic logic [31:0] ck_word(input logic [31:0] c);
    return {c[7:0], c[15:8], c[23:16], c[31:24]};
  endfunction

  // send a body of n bytes and check the buffer image
  task automatic t_tx(input int n, input int seed);
    int np = (n + 3) / 4 * 4;
    int s0 = n_start;
    int lb = len_bad;
    logic [31:0] c;
    for (int i = 0; i < 64; i++) pkt[i] = (i < n) ? 8'(seed + 13 * i) : 8'd0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_in_valid = 1; tx_in_data = pkt[i]; tx_in_last = (i == n - 1);
      while (!tx_in_ready) @(negedge clk);
    end
    @(negedge clk);
    tx_in_valid = 0; tx_in_last = 0;
    while (n_start == s0) @(negedge clk);
    @(negedge clk);
    chk("R1", "frame length", 64'(lat_len), 64'(np + 4));
    for (int w = 0; w < np / 4; w++) chk("R3", "body word", 64'(mem[w]), 64'(sw_word(w)));
    c = ref_crc(np);
    chk("R2", "checksum word", 64'(mem[np/4]), 64'(ck_word(c)));
    chk("R4", "single start pulse", 64'(n_start - s0), 64'd1);
    chk("R4", "length settled before start", 64'(len_bad - lb), 64'd0);
  endtask

  // place a frame with an n-byte body in the receive half and run it
  task automatic t_rx(input int n, input int seed, input bit corrupt);
    int ok0 = n_ok, cor0 = n_cor, pc0 = n_pclr, l0 = n_last;
    for (int i = 0; i < n; i++) pkt[i] = 8'(seed + 29 * i);
    for (int w = 0; w < n / 4; w++) mem[RXB + w] = sw_word(w);
    mem[RXB + n/4] = ck_word(ref_crc(n));
    if (corrupt) mem[RXB] = mem[RXB] ^ 32'h0001_0000;
    out_q.delete();
    @(negedge clk);
    rx_len = LENW'(n + 4); rx_present = 1;
    while (rx_present) @(negedge clk);
    repeat (3) @(negedge clk);
    if (!corrupt) begin
      chk("R8", "byte count", 64'(out_q.size()), 64'(n));
      for (int i = 0; i < n && i < out_q.size(); i++) chk("R8", "byte value", 64'(out_q[i]), 64'(pkt[i]));
      chk("R8", "ok pulse", 64'(n_ok - ok0), 64'd1);
      chk("R8", "last marker", 64'(n_last - l0), 64'd1);
    end else begin
      chk("R7", "corrupt pulse", 64'(n_cor - cor0), 64'd1);
      chk("R7", "no bytes released", 64'(out_q.size()), 64'd0);
      chk("R7", "no ok", 64'(n_ok - ok0), 64'd0);
    end
    chk("R10", "one present clear", 64'(n_pclr - pc0), 64'd1);
  endtask

  task automatic t_short();
    int s0 = n_sh, pc0 = n_pclr;
    out_q.delete();
    @(negedge clk);
    rx_len = LENW'(4); rx_present = 1;
    while (rx_present) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6", "short pulse", 64'(n_sh - s0), 64'd1);
    chk("R6", "no bytes released", 64'(out_q.size()), 64'd0);
    chk("R10", "one present clear", 64'(n_pclr - pc0), 64'd1);
  endtask

  task automatic t_overflow();
    int o0 = n_ovf, ok0 = n_ok;
    for (int i = 0; i < 8; i++) pkt[i] = 8'(i + 1);
    mem[RXB] = sw_word(0); mem[RXB+1] = sw_word(1); mem[RXB+2] = ck_word(ref_crc(8));
    out_q.delete();
    @(negedge clk);
    rx_len = LENW'(12); rx_present = 1; rx_overflow = 1;
    while (rx_present || rx_overflow) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9", "overflow pulse", 64'(n_ovf - o0), 64'd1);
    chk("R9", "no bytes released", 64'(out_q.size()), 64'd0);
    chk("R9", "no ok", 64'(n_ok - ok0), 64'd0);
    chk("R9", "present clear one cycle before error clear", 64'(eclr_cyc - pclr_cyc), 64'd1);
  endtask

  task automatic t_busy();
    int c0;
    busy_hold = 40;
    t_tx(4, 8'h50);
    chk("R5", "busy after start", 64'(tx_busy), 64'd1);
    chk("R5", "ready low while busy", 64'(tx_in_ready), 64'd0);
    c0 = start_cyc;
    t_tx(3, 8'h61);
    chk("R5", "next start waits for busy", 64'((start_cyc - c0) >= 40), 64'd1);
    busy_hold = 4;
  endtask

  task automatic t_loopback();
    int ok0 = n_ok;
    t_tx(10, 8'h33);
    repeat (6) @(negedge clk);
    for (int w = 0; w < 4; w++) mem[RXB + w] = mem[w];
    out_q.delete();
    @(negedge clk);
    rx_len = lat_len; rx_present = 1;
    while (rx_present) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8", "loopback byte count", 64'(out_q.size()), 64'd12);
    for (int i = 0; i < 12 && i < out_q.size(); i++) chk("R8", "loopback byte", 64'(out_q[i]), 64'(pkt[i]));
    chk("R8", "loopback ok", 64'(n_ok - ok0), 64'd1);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string s = "123456789";
    for (int i = 0; i < 9; i++) pkt[i] = s[i];
    chk("R2", "reference checksum self-test", 64'(ref_crc(9)), 64'hCBF43926);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11", "tx_start idle", 64'(tx_start), 64'd0);
    chk("R11", "no write", 64'(buf_wr_en), 64'd0);
    chk("R11", "no output", 64'(rx_out_valid), 64'd0);
    chk("R11", "no status", 64'({st_ok, st_corrupt, st_short, st_overflow}), 64'd0);
    chk("R11", "no clears", 64'({rx_present_clr, rx_error_clr}), 64'd0);
    chk("R11", "ready when idle", 64'(tx_in_ready), 64'd1);
    t_tx(8, 8'h10);   // aligned, no padding
    repeat (6) @(negedge clk);
    t_tx(5, 8'hA0);   // three pad bytes
    repeat (6) @(negedge clk);
    t_tx(1, 8'h7E);   // single byte body
    repeat (6) @(negedge clk);
    t_busy();
    repeat (45) @(negedge clk);
    t_rx(8, 8'h21, 1'b0);
    t_rx(4, 8'h90, 1'b0);  // minimum legal frame
    t_rx(60, 8'h05, 1'b0);
    t_rx(16, 8'h44, 1'b1);
    t_short();
    t_overflow();
    t_loopback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule